// File: doc/BRIEF.md
# Comparator-Aware Reservation Station Dispatch Allocator

This block sits at dispatch in front of a pool of reservation stations that do not all have the same number of tag comparators. Some stations watch two source tags, some watch one, and some watch none. For each dispatching instruction, the block reads a per-register ready scoreboard and counts how many of its source operands are still outstanding. It then grants the cheapest free station that has enough comparators for that count. If no suitable station is free, it raises a stall.

An instruction may have two outstanding operands when every two-comparator station is busy. In that case the block may still place it in a one-comparator station. A table of 2-bit counters predicts which operand will arrive last, and the station watches only that tag. The table is indexed by the instruction address XOR-ed with a global outcome history.

The guess can be wrong. A set of register-read check ports, one per issue lane, look up the same scoreboard. A check port flags any issuing instruction whose operands are not all ready, and a flush is requested. The pipeline drives the training port with the observed arrival order. It returns the station numbers that become free, and it reports result broadcasts that mark registers ready.

Top module: `tagelim_dispatch`

## Requirements
- R1: After reset, every station is free, every register reads as ready, every predictor counter holds 1, the history register holds 0, and `rr_bad` and `flush_req` are low.
- R2: An operand is outstanding when its present flag is set and its register is not ready. A granted dispatch whose `disp_dst_valid` is set marks `disp_dst` not ready. A `wb_valid` broadcast marks `wb_tag` ready. Both take effect from the next cycle, and when both name the same register in one cycle, the register ends up not ready.
- R3: With no outstanding operand, a zero-comparator station is granted first, then a one-comparator station, then a two-comparator station, and `disp_watch` is 2'b00 for a zero-comparator grant.
- R4: With one outstanding operand, a one-comparator station is granted first, then a two-comparator station. In both cases `disp_watch` has bit 0 set for operand A or bit 1 set for operand B, naming the outstanding operand.
- R5: With two outstanding operands and a free two-comparator station, that station is granted with `disp_watch` = 2'b11 and `disp_split` low.
- R6: Slot numbers place the two-comparator stations first (0 to N_TWO-1), then the one-comparator stations, then the zero-comparator stations. Within a class, the lowest free slot is granted.
- R7: With two outstanding operands and no free two-comparator station, a free one-comparator station is granted with `disp_split` high. `disp_watch` is then 2'b10 when the indexed counter is 2 or more, and 2'b01 otherwise.
- R8: When no adequate station is free, `disp_stall` is high during the dispatch cycle. The stalled dispatch occupies no station and changes no scoreboard entry.
- R9: `disp_pidx` equals `disp_pc[PHT_BITS-1:0]` XOR the history register, combinationally.
- R10: A training event increments (`train_b_last`=1) or decrements the counter at `train_idx`, saturating at 3 and 0. It also shifts `train_b_last` into bit 0 of the history register. Both changes are seen from the next cycle.
- R11: For each check port `i`, `rr_bad[i]` is high in the cycle after `rr_valid[i]` when either used operand was not ready. `flush_req` is the OR of those results.
- R12: A bit set in `st_release` frees that slot from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | Instruction address |
| disp_src_a | input | TAG_W | Operand A register |
| disp_has_a | input | 1 | Operand A present |
| disp_src_b | input | TAG_W | Operand B register |
| disp_has_b | input | 1 | Operand B present |
| disp_dst | input | TAG_W | Destination register |
| disp_dst_valid | input | 1 | Destination present |
| disp_stall | output | 1 | No adequate station free |
| disp_slot | output | SLOT_W | Granted slot |
| disp_watch | output | 2 | Tags the station watches (bit0 A, bit1 B) |
| disp_split | output | 1 | Grant relies on last-arrival prediction |
| disp_pidx | output | PHT_BITS | Predictor index used |
| st_release | input | NS | Slots to free |
| wb_valid | input | 1 | Result broadcast |
| wb_tag | input | TAG_W | Broadcast register |
| train_valid | input | 1 | Predictor training event |
| train_idx | input | PHT_BITS | Counter to train |
| train_b_last | input | 1 | Operand B arrived last |
| rr_valid | input | ISSUE_W | Register-read check per lane |
| rr_src_a | input | ISSUE_W*TAG_W | Operand A register per lane |
| rr_use_a | input | ISSUE_W | Operand A used per lane |
| rr_src_b | input | ISSUE_W*TAG_W | Operand B register per lane |
| rr_use_b | input | ISSUE_W | Operand B used per lane |
| rr_bad | output | ISSUE_W | Lane found an unready operand |
| flush_req | output | 1 | Misprediction flush request |

## Verification
The grant outputs (`disp_stall`, `disp_slot`, `disp_watch`, `disp_split`, `disp_pidx`) settle in the same cycle as the request. The bench drives them on the falling edge and reads them one nanosecond later. Station occupancy, scoreboard changes and training become visible only after the next rising edge, so each of those effects is checked through a later dispatch or check request. `rr_bad` and `flush_req` are registered and are read in the cycle after the check request. The bench samples them after that rising edge and verifies that they drop again one cycle later.

// File: rtl/tagelim_pkg.sv
package tagelim_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_ONE  = 2'd1,
        CLS_TWO  = 2'd2,
        CLS_NONE = 2'd3
    } st_class_e;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } pick_t;

    typedef struct packed {
        logic      pend_a;
        logic      pend_b;
        logic [1:0] need;
    } op_need_t;

    // lowest set bit of a free vector (up to 32 stations per class)
    function automatic pick_t pick_lowest(input logic [31:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = 5'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        logic [1:0] r;
        if (up) r = (c == 2'd3) ? c : c + 2'd1;
        else    r = (c == 2'd0) ? c : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/tagelim_scoreboard.sv
module tagelim_scoreboard #(
    parameter int NREG  = 16,
    parameter int TAG_W = $clog2(NREG),
    parameter int NRD   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       set_v,
    input  logic [TAG_W-1:0]           set_tag,
    input  logic                       clr_v,
    input  logic [TAG_W-1:0]           clr_tag,
    input  logic [NRD-1:0][TAG_W-1:0]  rd_tag,
    output logic [NRD-1:0]             rd_rdy
);
    logic [NREG-1:0] rdy_q, rdy_d;

    always_comb begin
        rdy_d = rdy_q;
        if (set_v) rdy_d[set_tag] = 1'b1;
        if (clr_v) rdy_d[clr_tag] = 1'b0;   // a new producer overrides a stale broadcast
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= '1;
        else     rdy_q <= rdy_d;
    end

    for (genvar gi = 0; gi < NRD; gi++) begin : g_rd
        assign rd_rdy[gi] = rdy_q[rd_tag[gi]];
    end

    // R2
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_v |=> !rdy_q[$past(clr_tag)]);

    // R2
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (set_v && !(clr_v && clr_tag == set_tag)) |=> rdy_q[$past(set_tag)]);

endmodule

// File: rtl/tagelim_lastpred.sv
module tagelim_lastpred import tagelim_pkg::*; #(
    parameter int PC_W     = 16,
    parameter int PHT_BITS = 6,
    parameter int PHT_N    = 1 << PHT_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PC_W-1:0]     pc,
    output logic [PHT_BITS-1:0] idx,
    output logic                b_last,
    input  logic                train_v,
    input  logic [PHT_BITS-1:0] train_idx,
    input  logic                train_b_last
);
    logic [1:0]          pht_q [PHT_N];
    logic [PHT_BITS-1:0] ghr_q;

    assign idx    = pc[PHT_BITS-1:0] ^ ghr_q;
    assign b_last = pht_q[idx][1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHT_N; i++) pht_q[i] <= 2'd1;
            ghr_q <= '0;
        end else if (train_v) begin
            pht_q[train_idx] <= ctr_step(pht_q[train_idx], train_b_last);
            ghr_q            <= {ghr_q[PHT_BITS-2:0], train_b_last};
        end
    end

    // R10
    ghr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        train_v |=> ghr_q[0] == $past(train_b_last));

    // R10
    ghr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !train_v |=> $stable(ghr_q));

endmodule

// File: rtl/tagelim_alloc.sv
module tagelim_alloc import tagelim_pkg::*; #(
    parameter int N_TWO  = 2,
    parameter int N_ONE  = 2,
    parameter int N_ZERO = 2,
    parameter int NS     = N_TWO + N_ONE + N_ZERO,
    parameter int SLOT_W = $clog2(NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        need,
    input  logic [NS-1:0]     st_free_i,
    output logic              grant,
    output logic [SLOT_W-1:0] slot,
    output st_class_e         cls,
    output logic              split
);
    localparam int BASE_ONE  = N_TWO;
    localparam int BASE_ZERO = N_TWO + N_ONE;

    logic [NS-1:0] busy_q;
    logic [31:0]   f2, f1, f0;
    pick_t         p2, p1, p0;

    always_comb begin
        f2 = '0;
        f1 = '0;
        f0 = '0;
        for (int i = 0; i < N_TWO; i++)  f2[i] = ~busy_q[i];
        for (int i = 0; i < N_ONE; i++)  f1[i] = ~busy_q[BASE_ONE + i];
        for (int i = 0; i < N_ZERO; i++) f0[i] = ~busy_q[BASE_ZERO + i];
        p2 = pick_lowest(f2);
        p1 = pick_lowest(f1);
        p0 = pick_lowest(f0);
    end

    always_comb begin
        cls   = CLS_NONE;
        split = 1'b0;
        unique case (need)
            2'd0: begin
                if      (p0.hit) cls = CLS_ZERO;
                else if (p1.hit) cls = CLS_ONE;
                else if (p2.hit) cls = CLS_TWO;
            end
            2'd1: begin
                if      (p1.hit) cls = CLS_ONE;
                else if (p2.hit) cls = CLS_TWO;
            end
            default: begin
                if (p2.hit) cls = CLS_TWO;
                else if (p1.hit) begin
                    cls   = CLS_ONE;
                    split = 1'b1;
                end
            end
        endcase
        unique case (cls)
            CLS_ZERO: slot = SLOT_W'(p0.idx) + SLOT_W'(BASE_ZERO);
            CLS_ONE:  slot = SLOT_W'(p1.idx) + SLOT_W'(BASE_ONE);
            CLS_TWO:  slot = SLOT_W'(p2.idx);
            default:  slot = '0;
        endcase
    end

    assign grant = req && (cls != CLS_NONE);

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else begin
            busy_q <= busy_q & ~st_free_i;
            if (grant) busy_q[slot] <= 1'b1;
        end
    end

    // R8
    grant_free_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> !busy_q[slot]);

    // R8
    grant_marks_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> busy_q[$past(slot)]);

    for (genvar gi = 0; gi < NS; gi++) begin : g_rel
        // R12
        release_chk: assert property (@(posedge clk) disable iff (rst)
            (st_free_i[gi] && !(grant && slot == SLOT_W'(gi))) |=> !busy_q[gi]);
    end

endmodule

// File: rtl/tagelim_dispatch.sv
module tagelim_dispatch import tagelim_pkg::*; #(
    parameter int N_TWO    = 2,
    parameter int N_ONE    = 2,
    parameter int N_ZERO   = 2,
    parameter int NREG     = 16,
    parameter int PC_W     = 16,
    parameter int PHT_BITS = 6,
    parameter int ISSUE_W  = 2,
    parameter int NS       = N_TWO + N_ONE + N_ZERO,
    parameter int SLOT_W   = $clog2(NS),
    parameter int TAG_W    = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     disp_valid,
    input  logic [PC_W-1:0]          disp_pc,
    input  logic [TAG_W-1:0]         disp_src_a,
    input  logic                     disp_has_a,
    input  logic [TAG_W-1:0]         disp_src_b,
    input  logic                     disp_has_b,
    input  logic [TAG_W-1:0]         disp_dst,
    input  logic                     disp_dst_valid,
    output logic                     disp_stall,
    output logic [SLOT_W-1:0]        disp_slot,
    output logic [1:0]               disp_watch,
    output logic                     disp_split,
    output logic [PHT_BITS-1:0]      disp_pidx,
    input  logic [NS-1:0]            st_release,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_tag,
    input  logic                     train_valid,
    input  logic [PHT_BITS-1:0]      train_idx,
    input  logic                     train_b_last,
    input  logic [ISSUE_W-1:0]       rr_valid,
    input  logic [ISSUE_W*TAG_W-1:0] rr_src_a,
    input  logic [ISSUE_W-1:0]       rr_use_a,
    input  logic [ISSUE_W*TAG_W-1:0] rr_src_b,
    input  logic [ISSUE_W-1:0]       rr_use_b,
    output logic [ISSUE_W-1:0]       rr_bad,
    output logic                     flush_req
);
    localparam int NRD = 2 + 2 * ISSUE_W;

    logic [NRD-1:0][TAG_W-1:0] rd_tag;
    logic [NRD-1:0]            rd_rdy;
    op_need_t                  opn;
    logic                      grant, split, pred_b;
    st_class_e                 cls;
    logic [ISSUE_W-1:0]        bad_d;

    always_comb begin
        rd_tag[0] = disp_src_a;
        rd_tag[1] = disp_src_b;
        for (int i = 0; i < ISSUE_W; i++) begin
            rd_tag[2 + 2*i] = rr_src_a[i*TAG_W +: TAG_W];
            rd_tag[3 + 2*i] = rr_src_b[i*TAG_W +: TAG_W];
        end
    end

    tagelim_scoreboard #(.NREG(NREG), .TAG_W(TAG_W), .NRD(NRD)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_v   (wb_valid),
        .set_tag (wb_tag),
        .clr_v   (grant && disp_dst_valid),
        .clr_tag (disp_dst),
        .rd_tag  (rd_tag),
        .rd_rdy  (rd_rdy)
    );

    always_comb begin
        opn.pend_a = disp_has_a && !rd_rdy[0];
        opn.pend_b = disp_has_b && !rd_rdy[1];
        opn.need   = {1'b0, opn.pend_a} + {1'b0, opn.pend_b};
    end

    tagelim_alloc #(.N_TWO(N_TWO), .N_ONE(N_ONE), .N_ZERO(N_ZERO),
                    .NS(NS), .SLOT_W(SLOT_W)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .req       (disp_valid),
        .need      (opn.need),
        .st_free_i (st_release),
        .grant     (grant),
        .slot      (disp_slot),
        .cls       (cls),
        .split     (split)
    );

    tagelim_lastpred #(.PC_W(PC_W), .PHT_BITS(PHT_BITS)) u_pred (
        .clk          (clk),
        .rst          (rst),
        .pc           (disp_pc),
        .idx          (disp_pidx),
        .b_last       (pred_b),
        .train_v      (train_valid),
        .train_idx    (train_idx),
        .train_b_last (train_b_last)
    );

    always_comb begin
        unique case (cls)
            CLS_TWO:  disp_watch = {opn.pend_b, opn.pend_a};
            CLS_ONE:  disp_watch = split ? (pred_b ? 2'b10 : 2'b01)
                                         : {opn.pend_b, opn.pend_a};
            default:  disp_watch = 2'b00;
        endcase
    end

    assign disp_stall = disp_valid && !grant;
    assign disp_split = grant && split;

    always_comb begin
        for (int i = 0; i < ISSUE_W; i++)
            bad_d[i] = rr_valid[i] && ((rr_use_a[i] && !rd_rdy[2 + 2*i]) ||
                                       (rr_use_b[i] && !rd_rdy[3 + 2*i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_bad    <= '0;
            flush_req <= 1'b0;
        end else begin
            rr_bad    <= bad_d;
            flush_req <= |bad_d;
        end
    end

    // R7
    split_one_chk: assert property (@(posedge clk) disable iff (rst)
        disp_split |-> ($countones(disp_watch) == 1 && !disp_stall));

    // R8
    stall_req_chk: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> disp_valid);

    // R11
    rr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rr_valid) == '0) |-> !flush_req);

    // R3
    zero_watch_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_stall && disp_slot >= SLOT_W'(N_TWO + N_ONE)) |-> disp_watch == 2'b00);

endmodule

// File: tb/tagelim_dispatch_tb.sv
module tagelim_dispatch_tb;
    localparam int TAG_W = 4;
    localparam int NS    = 6;

    logic clk = 1'b0;
    logic rst;
    logic disp_valid, disp_has_a, disp_has_b, disp_dst_valid;
    logic [15:0] disp_pc;
    logic [TAG_W-1:0] disp_src_a, disp_src_b, disp_dst, wb_tag;
    logic disp_stall, disp_split;
    logic [2:0] disp_slot;
    logic [1:0] disp_watch;
    logic [5:0] disp_pidx, train_idx;
    logic [NS-1:0] st_release;
    logic wb_valid, train_valid, train_b_last;
    logic [1:0] rr_valid, rr_use_a, rr_use_b, rr_bad;
    logic [2*TAG_W-1:0] rr_src_a, rr_src_b;
    logic flush_req;

    int total = 0;
    int bad = 0;
    int s_stall, s_slot, s_watch, s_split, s_pidx;

    always #5 clk = ~clk;

    tagelim_dispatch u_dut (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_pc(disp_pc),
        .disp_src_a(disp_src_a), .disp_has_a(disp_has_a),
        .disp_src_b(disp_src_b), .disp_has_b(disp_has_b),
        .disp_dst(disp_dst), .disp_dst_valid(disp_dst_valid),
        .disp_stall(disp_stall), .disp_slot(disp_slot), .disp_watch(disp_watch),
        .disp_split(disp_split), .disp_pidx(disp_pidx), .st_release(st_release),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .train_valid(train_valid),
        .train_idx(train_idx), .train_b_last(train_b_last),
        .rr_valid(rr_valid), .rr_src_a(rr_src_a), .rr_use_a(rr_use_a),
        .rr_src_b(rr_src_b), .rr_use_b(rr_use_b), .rr_bad(rr_bad),
        .flush_req(flush_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 0; disp_pc = '0; disp_src_a = '0; disp_has_a = 0;
        disp_src_b = '0; disp_has_b = 0; disp_dst = '0; disp_dst_valid = 0;
        st_release = '0; wb_valid = 0; wb_tag = '0; train_valid = 0;
        train_idx = '0; train_b_last = 0; rr_valid = '0; rr_use_a = '0;
        rr_use_b = '0; rr_src_a = '0; rr_src_b = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drives one dispatch at a falling edge, records the same-cycle result
    task automatic disp(input int pc, input int a, input bit ha, input int b,
                        input bit hb, input int dst, input bit dv);
        disp_valid = 1; disp_pc = 16'(pc);
        disp_src_a = TAG_W'(a); disp_has_a = ha;
        disp_src_b = TAG_W'(b); disp_has_b = hb;
        disp_dst = TAG_W'(dst); disp_dst_valid = dv;
        #1;
        s_stall = int'(disp_stall); s_slot = int'(disp_slot);
        s_watch = int'(disp_watch); s_split = int'(disp_split);
        s_pidx = int'(disp_pidx);
        @(negedge clk);
        disp_valid = 0; disp_dst_valid = 0;
    endtask

    task automatic release_slot(input int s);
        st_release = '0;
        st_release[s] = 1'b1;
        @(negedge clk);
        st_release = '0;
    endtask

    task automatic train(input int idx, input bit bl);
        train_valid = 1; train_idx = 6'(idx); train_b_last = bl;
        @(negedge clk);
        train_valid = 0;
    endtask

    // single-lane read check on one register; returns rr_bad[0] after the edge
    task automatic rr_one(input int r, output int res);
        rr_valid = 2'b01; rr_use_a = 2'b01; rr_src_a = {TAG_W'(0), TAG_W'(r)};
        @(posedge clk); #1;
        res = int'(rr_bad[0]);
        @(negedge clk);
        rr_valid = '0; rr_use_a = '0;
    endtask

    task automatic t_reset();
        int r;
        do_reset();
        check("R1 flush after reset", int'(flush_req), 0);
        check("R1 rr_bad after reset", int'(rr_bad), 0);
        rr_one(5, r);
        check("R1 register ready after reset", r, 0);
        disp(0, 1, 1, 2, 1, 0, 0);
        check("R1 no stall on empty pool", s_stall, 0);
        check("R3 need0 takes zero class", s_slot, 4);
        check("R3 zero class watches nothing", s_watch, 0);
    endtask

    task automatic t_classes();
        int r;
        int exp_slot [6] = '{4, 5, 2, 3, 0, 1};
        do_reset();
        foreach (exp_slot[i]) begin
            disp(0, 0, 0, 0, 0, 0, 0);
            check("R3 R6 escalation order", s_slot, exp_slot[i]);
            check("R3 granted", s_stall, 0);
        end
        disp(0, 0, 0, 0, 0, 9, 1);
        check("R8 stall when pool full", s_stall, 1);
        rr_one(9, r);
        check("R8 stalled dispatch leaves scoreboard", r, 0);
        release_slot(3);
        disp(0, 0, 0, 0, 0, 0, 0);
        check("R8 stalled dispatch held no station", s_slot, 3);
    endtask

    task automatic t_one();
        do_reset();
        disp(0, 0, 0, 0, 0, 3, 1);
        check("R2 producer dispatch", s_slot, 4);
        disp(0, 3, 1, 0, 0, 0, 0);
        check("R4 need1 takes one class", s_slot, 2);
        check("R4 watches A", s_watch, 1);
        disp(0, 7, 1, 3, 1, 0, 0);
        check("R4 second one-class slot", s_slot, 3);
        check("R4 watches B", s_watch, 2);
        disp(0, 3, 1, 0, 0, 0, 0);
        check("R4 escalates to two class", s_slot, 0);
        check("R4 two class watches A only", s_watch, 1);
        wb_valid = 1; wb_tag = 4'd3;
        @(negedge clk);
        wb_valid = 0;
        disp(0, 3, 1, 0, 0, 0, 0);
        check("R2 wakeup makes operand ready", s_slot, 5);
    endtask

    task automatic t_two();
        do_reset();
        disp(0, 0, 0, 0, 0, 3, 1);
        disp(0, 0, 0, 0, 0, 4, 1);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R5 need2 slot", s_slot, 0);
        check("R5 watches both", s_watch, 3);
        check("R5 no split", s_split, 0);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R6 next two-class slot", s_slot, 1);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R7 split slot", s_slot, 2);
        check("R7 split flag", s_split, 1);
        check("R7 weak counter picks A", s_watch, 1);
        check("R9 index with zero history", s_pidx, 16);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R7 second split slot", s_slot, 3);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R8 need2 stall", s_stall, 1);
        release_slot(1);
        disp(16, 3, 1, 4, 1, 0, 0);
        check("R12 released slot reused", s_slot, 1);
        check("R12 full watch on two class", s_watch, 3);
    endtask

    task automatic t_pred();
        do_reset();
        train(5, 1);
        train(5, 1);                       // counter 3, history 000011
        disp(0, 0, 0, 0, 0, 3, 1);
        disp(0, 0, 0, 0, 0, 4, 1);
        disp(0, 3, 1, 4, 1, 0, 0);
        disp(0, 3, 1, 4, 1, 0, 0);
        disp(6, 3, 1, 4, 1, 0, 0);
        check("R9 index xor history", s_pidx, 5);
        check("R10 trained counter picks B", s_watch, 2);
        release_slot(2);
        train(5, 0);                       // counter 2, history 000110
        disp(3, 3, 1, 4, 1, 0, 0);
        check("R9 index after shift", s_pidx, 5);
        check("R10 counter 2 still B", s_watch, 2);
        release_slot(2);
        train(5, 0);                       // counter 1, history 001100
        disp(9, 3, 1, 4, 1, 0, 0);
        check("R9 index after second shift", s_pidx, 5);
        check("R10 counter 1 picks A", s_watch, 1);
        release_slot(2);
        train(5, 0); train(5, 0); train(5, 0);   // counter floor 0, history 100000
        train(5, 1);                       // counter 1, history 000001
        disp(4, 3, 1, 4, 1, 0, 0);
        check("R10 floor saturation", s_watch, 1);
        check("R9 index pc4", s_pidx, 5);
    endtask

    task automatic t_rr();
        int r;
        do_reset();
        disp(0, 0, 0, 0, 0, 6, 1);
        rr_valid = 2'b11; rr_use_a = 2'b11; rr_use_b = 2'b10;
        rr_src_a = {4'd1, 4'd6}; rr_src_b = {4'd2, 4'd0};
        @(posedge clk); #1;
        check("R11 lane0 bad", int'(rr_bad), 1);
        check("R11 flush raised", int'(flush_req), 1);
        @(negedge clk);
        rr_valid = 2'b01; rr_use_a = 2'b00; rr_use_b = 2'b00;
        @(posedge clk); #1;
        check("R11 unused operand ignored", int'(rr_bad), 0);
        check("R11 flush clears", int'(flush_req), 0);
        @(negedge clk);
        rr_valid = '0;
        rr_src_a = {4'd6, 4'd0}; rr_use_a = 2'b10; rr_valid = 2'b10;
        @(posedge clk); #1;
        check("R11 lane1 bad", int'(rr_bad), 2);
        @(negedge clk);
        rr_valid = '0; rr_use_a = '0;
        wb_valid = 1; wb_tag = 4'd8;
        disp(0, 0, 0, 0, 0, 8, 1);
        wb_valid = 0;
        rr_one(8, r);
        check("R2 clear wins over same-cycle wakeup", r, 1);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        t_reset();
        t_classes();
        t_one();
        t_two();
        t_pred();
        t_rr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule